// File: doc/BRIEF.md
# Write Channel Ordering Monitor

A passive observer for the write side of an AXI4 port. It watches the address, data and response handshakes. It never drives the bus. It reports any traffic that breaks the write ordering rules. Each accepted address is recorded in a slot table together with its ID and burst length. The data beats must then drain those addresses strictly oldest first, with no interleaving between bursts. Each response must retire the oldest outstanding transaction that carries its ID. Responses with different IDs may return in any order. A response whose ID has nothing outstanding is reported.

The monitor also enforces a parameterised ceiling on outstanding writes. Every violation produces a one-cycle pulse on a dedicated error output in the cycle after the offending handshake. The block is placed beside a bus port in simulation or in silicon debug logic. The read channels are not connected to it.

Top module: `wr_order_monitor`

## Requirements
- R1: A handshake on any channel takes effect only in a cycle where both its valid and its ready input are high. A valid input held without ready changes neither the error outputs nor the recorded state.
- R2: A data beat must belong to the oldest address whose data is still incomplete. If the beat's ID differs from that address's ID, `err_w_order_o` pulses. The beat is still counted against that oldest address.
- R3: A data beat that arrives when no address is open, and with no address accepted in the same cycle, pulses `err_w_order_o`.
- R4: When no address is open, a data beat accepted in the same cycle as an address belongs to that new address.
- R5: Each burst expects `aw_len_i + 1` beats. If the last-beat flag is high on an earlier beat, or low on the final expected beat, `err_last_o` pulses. The burst is closed in either case.
- R6: Responses for different IDs may arrive in any order once their data is complete, and raise no error.
- R7: A response retires the oldest outstanding transaction with a matching ID. If that transaction's data is not yet complete, `err_b_early_o` pulses. A beat that closes the data in the same cycle counts as complete.
- R8: A response whose ID matches no outstanding transaction pulses `err_b_unexp_o`.
- R9: An address accepted while `MAX_OUT` writes are outstanding pulses `err_limit_o` and is not recorded.
- R10: Reset clears all recorded transactions and the beat counter, and holds every error output low.
- R11: Each error output is registered. It is high only in the cycle after the handshake that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aw_valid_i | input | 1 | Address valid |
| aw_ready_i | input | 1 | Address ready |
| aw_id_i | input | ID_W | Address ID |
| aw_len_i | input | 8 | Burst length minus one |
| w_valid_i | input | 1 | Data valid |
| w_ready_i | input | 1 | Data ready |
| w_id_i | input | ID_W | Data ID |
| w_last_i | input | 1 | Last beat of burst |
| b_valid_i | input | 1 | Response valid |
| b_ready_i | input | 1 | Response ready |
| b_id_i | input | ID_W | Response ID |
| err_w_order_o | output | 1 | Data beat out of address order, or with no open address |
| err_last_o | output | 1 | Last-beat flag disagrees with the burst length |
| err_b_early_o | output | 1 | Response arrived before its data completed |
| err_b_unexp_o | output | 1 | Response ID has no outstanding write |
| err_limit_o | output | 1 | Outstanding-write ceiling exceeded |

## Verification
The bench drives sequences that tell correct ordering apart from each kind of fault:
- Two bursts with different IDs whose responses return in reverse order.
- A single-beat burst whose data arrives in the same cycle as its address.
- Data that jumps to a younger address.
- Last-beat flags placed early and late.
- Two same-ID writes where the second response arrives before its data.
- A response for an unknown ID.
- A fill of all outstanding slots followed by one more address.

Valid-without-ready cycles show that an incomplete handshake is ignored. Idle steps after each fault show that every error is a single pulse.

// File: rtl/wr_mon_pkg.sv
package wr_mon_pkg;
  localparam int unsigned AXI_LEN_W = 8;

  typedef struct packed {
    logic limit;
    logic b_unexp;
    logic b_early;
    logic last;
    logic order;
  } wr_err_t;
endpackage

// File: rtl/wr_age_matrix.sv
// older_o[j*N+i] set: slot j was allocated before slot i
module wr_age_matrix #(
  parameter int unsigned N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   alloc_i,
  output logic [N*N-1:0] older_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_o <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < N; j++) begin
            older_o[j*N+k] <= (j != k);
            older_o[k*N+j] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wr_oldest_pick.sv
module wr_oldest_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   req_i,
  input  logic [N*N-1:0] older_i,
  output logic [N-1:0]   gnt_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && req_i[j] && older_i[j*N+i]) beaten = 1'b1;
      gnt_o[i] = req_i[i] && !beaten;
    end
  end
endmodule

// File: rtl/wr_free_pick.sv
module wr_free_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] used_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!used_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    any_o = |gnt_o;
  end
endmodule

// File: rtl/wr_order_monitor.sv
module wr_order_monitor
  import wr_mon_pkg::*;
#(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned MAX_OUT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aw_valid_i,
  input  logic                 aw_ready_i,
  input  logic [ID_W-1:0]      aw_id_i,
  input  logic [AXI_LEN_W-1:0] aw_len_i,
  input  logic                 w_valid_i,
  input  logic                 w_ready_i,
  input  logic [ID_W-1:0]      w_id_i,
  input  logic                 w_last_i,
  input  logic                 b_valid_i,
  input  logic                 b_ready_i,
  input  logic [ID_W-1:0]      b_id_i,
  output logic                 err_w_order_o,
  output logic                 err_last_o,
  output logic                 err_b_early_o,
  output logic                 err_b_unexp_o,
  output logic                 err_limit_o
);
  localparam int unsigned N = MAX_OUT;

  logic [N-1:0]           slot_vld, slot_done;
  logic [ID_W-1:0]        slot_id  [N];
  logic [AXI_LEN_W-1:0]   slot_len [N];
  logic [AXI_LEN_W-1:0]   beat_cnt;
  logic [N*N-1:0]         older;
  wr_err_t                err_q, err_d;

  logic aw_fire, w_fire, b_fire;
  assign aw_fire = aw_valid_i && aw_ready_i;
  assign w_fire  = w_valid_i && w_ready_i;
  assign b_fire  = b_valid_i && b_ready_i;

  // slot allocation
  logic [N-1:0] free_gnt, alloc_vec;
  logic         free_any, aw_take;

  wr_free_pick #(.N(N)) u_free (
    .used_i (slot_vld),
    .gnt_o  (free_gnt),
    .any_o  (free_any)
  );

  assign aw_take   = aw_fire && free_any;
  assign alloc_vec = aw_take ? free_gnt : '0;

  wr_age_matrix #(.N(N)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_vec),
    .older_o (older)
  );

  // data head: oldest slot with data still open
  logic [N-1:0] w_req, w_gnt;
  logic         w_have;
  assign w_req = slot_vld & ~slot_done;

  wr_oldest_pick #(.N(N)) u_w_pick (
    .req_i   (w_req),
    .older_i (older),
    .gnt_o   (w_gnt)
  );
  assign w_have = |w_gnt;

  logic [ID_W-1:0]      head_id;
  logic [AXI_LEN_W-1:0] head_len;
  logic                 head_new, w_ok, last_exp, w_close;

  always_comb begin
    head_id  = '0;
    head_len = '0;
    for (int i = 0; i < N; i++)
      if (w_gnt[i]) begin
        head_id  = slot_id[i];
        head_len = slot_len[i];
      end
    if (!w_have) begin
      head_id  = aw_id_i;
      head_len = aw_len_i;
    end
  end

  assign head_new = !w_have && aw_take;
  assign w_ok     = w_have || aw_take;
  assign last_exp = (beat_cnt == head_len);
  assign w_close  = w_fire && w_ok && (w_last_i || last_exp);

  // response match: oldest outstanding slot with the same ID
  logic [N-1:0] b_req, b_gnt, w_close_vec, free_vec;
  logic         b_hit;

  always_comb
    for (int i = 0; i < N; i++)
      b_req[i] = slot_vld[i] && (slot_id[i] == b_id_i);

  wr_oldest_pick #(.N(N)) u_b_pick (
    .req_i   (b_req),
    .older_i (older),
    .gnt_o   (b_gnt)
  );

  assign b_hit       = |b_gnt;
  assign w_close_vec = (w_close && w_have) ? w_gnt : '0;
  assign free_vec    = (b_fire && b_hit) ? b_gnt : '0;

  always_comb begin
    err_d.order   = w_fire && (!w_ok || (w_id_i != head_id));
    err_d.last    = w_fire && w_ok && (w_last_i != last_exp);
    err_d.b_unexp = b_fire && !b_hit;
    err_d.b_early = b_fire && b_hit && !(|(b_gnt & (slot_done | w_close_vec)));
    err_d.limit   = aw_fire && !free_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld  <= '0;
      slot_done <= '0;
      beat_cnt  <= '0;
      err_q     <= '0;
      for (int i = 0; i < N; i++) begin
        slot_id[i]  <= '0;
        slot_len[i] <= '0;
      end
    end else begin
      err_q <= err_d;
      if (w_fire && w_ok) beat_cnt <= w_close ? '0 : beat_cnt + 1'b1;
      for (int i = 0; i < N; i++) begin
        if (free_vec[i]) slot_vld[i] <= 1'b0;
        if (w_close_vec[i]) slot_done[i] <= 1'b1;
        if (alloc_vec[i]) begin
          slot_vld[i]  <= 1'b1;
          slot_id[i]   <= aw_id_i;
          slot_len[i]  <= aw_len_i;
          slot_done[i] <= head_new && w_close;
        end
      end
    end
  end

  assign err_w_order_o = err_q.order;
  assign err_last_o    = err_q.last;
  assign err_b_early_o = err_q.b_early;
  assign err_b_unexp_o = err_q.b_unexp;
  assign err_limit_o   = err_q.limit;

  // R2
  w_head_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(w_gnt));
  // R3
  w_order_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_w_order_o |-> $past(w_valid_i && w_ready_i));
  // R5
  last_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_last_o |-> $past(w_valid_i && w_ready_i));
  // R8
  b_unexp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_b_unexp_o |-> $past(b_valid_i && b_ready_i));
  // R9
  limit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_limit_o |-> $past(aw_valid_i && aw_ready_i));
  // R7
  retire_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_fire && b_hit && !aw_take) |=> ($countones(slot_vld) + 1 == $past($countones(slot_vld))));
endmodule

// File: tb/wr_order_monitor_test.sv
module wr_order_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       awv = 0, awr = 0, wv = 0, wr = 0, wl = 0, bv = 0, br = 0;
  logic [3:0] awid = 0, wid = 0, bid = 0;
  logic [7:0] awlen = 0;
  logic       e_ord, e_last, e_early, e_unexp, e_lim;

  int checks = 0, fails = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #10 clk = ~clk;

  wr_order_monitor #(.ID_W(4), .MAX_OUT(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(awv), .aw_ready_i(awr), .aw_id_i(awid), .aw_len_i(awlen),
    .w_valid_i(wv), .w_ready_i(wr), .w_id_i(wid), .w_last_i(wl),
    .b_valid_i(bv), .b_ready_i(br), .b_id_i(bid),
    .err_w_order_o(e_ord), .err_last_o(e_last), .err_b_early_o(e_early),
    .err_b_unexp_o(e_unexp), .err_limit_o(e_lim)
  );

  // flags order: {limit, b_unexp, b_early, last, order}
  function automatic logic [4:0] flags();
    return {e_lim, e_unexp, e_early, e_last, e_ord};
  endfunction

  // monitor: compare outputs one cycle after each driven step
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (flags() !== e) begin
        fails++;
        $display("FAIL %s: flags=%b expected=%b", t, flags(), e);
      end
    end
  end

  task automatic step(input logic a_v, a_r, input logic [3:0] a_id, input logic [7:0] a_len,
                      input logic d_v, d_r, input logic [3:0] d_id, input logic d_l,
                      input logic r_v, r_r, input logic [3:0] r_id,
                      input logic [4:0] e, input string t);
    awv = a_v; awr = a_r; awid = a_id; awlen = a_len;
    wv = d_v; wr = d_r; wid = d_id; wl = d_l;
    bv = r_v; br = r_r; bid = r_id;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic aw(input logic [3:0] id, input logic [7:0] len, input logic [4:0] e, input string t);
    step(1, 1, id, len, 0, 0, 0, 0, 0, 0, 0, e, t);
  endtask
  task automatic w(input logic [3:0] id, input logic l, input logic [4:0] e, input string t);
    step(0, 0, 0, 0, 1, 1, id, l, 0, 0, 0, e, t);
  endtask
  task automatic b(input logic [3:0] id, input logic [4:0] e, input string t);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, id, e, t);
  endtask
  task automatic idle(input string t);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5'b0, t);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flags() !== 5'b0) begin
      fails++;
      $display("FAIL R10 reset: flags=%b expected=00000", flags());
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: valid without ready is ignored
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'b0, "R1 aw no ready");
    step(0, 0, 0, 0, 1, 0, 1, 1, 1, 0, 5, 5'b0, "R1 w/b no ready");
    w(1, 1, 5'b00001, "R1/R3 beat with no address");
    idle("R11 pulse clears");

    // R4: same-cycle address and data
    step(1, 1, 2, 0, 1, 1, 2, 1, 0, 0, 0, 5'b0, "R4 aw+w same cycle");
    b(2, 5'b0, "R4 response after same-cycle data");

    // R6: reverse-order responses across IDs
    aw(1, 1, 5'b0, "R6 aw A");
    aw(3, 0, 5'b0, "R6 aw B");
    w(1, 0, 5'b0, "R2 A beat0");
    w(1, 1, 5'b0, "R2 A last");
    w(3, 1, 5'b0, "R2 B last");
    b(3, 5'b0, "R6 B first");
    b(1, 5'b0, "R6 A second");

    // R2: data jumps to younger address
    aw(4, 0, 5'b0, "R2 aw id4");
    aw(5, 0, 5'b0, "R2 aw id5");
    w(5, 1, 5'b00001, "R2 beat for younger id");
    w(5, 1, 5'b0, "R2 beat now matches");
    b(4, 5'b0, "R2 retire id4");
    b(5, 5'b0, "R2 retire id5");

    // R5: early and late last flag
    aw(6, 1, 5'b0, "R5 aw len1");
    w(6, 1, 5'b00010, "R5 last too early");
    b(6, 5'b0, "R5 retire after early close");
    aw(6, 0, 5'b0, "R5 aw len0");
    w(6, 0, 5'b00010, "R5 last missing");
    b(6, 5'b0, "R5 retire after forced close");
    idle("R11 last pulse clears");

    // R7: same-ID responses in issue order
    aw(7, 0, 5'b0, "R7 aw X");
    aw(7, 0, 5'b0, "R7 aw Y");
    w(7, 1, 5'b0, "R7 X data");
    b(7, 5'b0, "R7 retire X");
    b(7, 5'b00100, "R7 Y response before data");
    w(7, 1, 5'b00001, "R7 Y retired so beat has no address");

    // R7: closing beat in same cycle as response is fine
    aw(9, 0, 5'b0, "R7 aw id9");
    step(0, 0, 0, 0, 1, 1, 9, 1, 1, 1, 9, 5'b0, "R7 data and response same cycle");

    // R8
    b(11, 5'b01000, "R8 unknown id");
    idle("R11 unexp pulse clears");

    // R9: fill and overflow
    aw(1, 0, 5'b0, "R9 fill 1");
    aw(2, 0, 5'b0, "R9 fill 2");
    aw(3, 0, 5'b0, "R9 fill 3");
    aw(4, 0, 5'b0, "R9 fill 4");
    aw(10, 0, 5'b10000, "R9 over limit");
    for (int i = 1; i <= 4; i++) w(4'(i), 1, 5'b0, "R9 drain data");
    w(10, 1, 5'b00001, "R9 dropped address has no data slot");
    for (int i = 1; i <= 4; i++) b(4'(i), 5'b0, "R9 retire");
    b(10, 5'b01000, "R9 dropped address has no response");
    idle("R11 final idle");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule